// File: doc/BRIEF.md
# Inductor Current Balancing Switch Assigner

This block sits between a multilevel modulator and the gate drivers of a converter built from NMOD parallel current-source modules. The modulator supplies a code for the present sixth of the fundamental cycle and, for each of the six switch positions (upper and lower for phases A, B and C), how many modules must have that switch closed. The block also receives the measured upper and lower sharing-inductor currents of every module and the three sampled phase voltages. From these it decides which module closes which switch.

In one kind of interval every module closes the upper switch of the phase at its peak, and the lower switches are shared out. In the other kind the roles of the upper and lower switches are swapped. The shared side is handed out by ranking. Modules are sorted by the current of the inductor on the shared side, lowest first. The phases are sorted by voltage, in the direction that drives the most current into a starved inductor. The lowest-current modules then fill the first phase's quota, the next modules fill the second phase's quota, and so on. Over many switching events this keeps the module currents close together without a control loop.

Each pulse of the PWM-change strobe starts a new assignment. The inputs are captured on that edge. Ranking proceeds one module per cycle. The new selects are then published together with a one-cycle valid pulse. Between pulses the previous selects are held unchanged.

Top module: `ind_balance_assigner`

## Requirements
- R1: For every module, `up_sel` and `low_sel` each hold exactly one set bit at all times: bit 0 is phase A, bit 1 is phase B and bit 2 is phase C. Module k uses bits 3k+2..3k. After reset, every module selects phase A on both sides and `sel_valid` is 0.
- R2: The value of `interval_code` decides which side is common. Codes 0, 2 and 4 make every module's upper select the peak phase (A, B and C respectively). Codes 1, 3 and 5 make every module's lower select the peak phase (C, A and B respectively). Code 6 behaves as 0 and code 7 behaves as 3.
- R3: `sw_count` holds six CW-bit fields. Field n sits at bits n*CW+CW-1..n*CW, in the order A-upper, A-lower, B-upper, B-lower, C-upper, C-lower. Only the three fields of the shared side are used. When those three fields sum to NMOD, the number of modules given each switch equals its field.
- R4: When the upper side is common, modules are ranked by ascending `i_lower`. The phases are ordered by descending voltage. The lowest-ranked modules go to the first phase.
- R5: When the lower side is common, modules are ranked by ascending `i_upper`. The phases are ordered by ascending voltage.
- R6: When two module currents are equal, the lower module index ranks first. When two phase voltages are equal, the order A before B before C applies. All currents and voltages are signed DW-bit values.
- R7: Let c0 and c1 be the quotas of the first two ordered phases. The module of rank r goes to the first phase if r < c0, to the second phase if r < c0 + c1, and otherwise to the third phase. This rule also applies when the quotas do not sum to NMOD.
- R8: A strobe accepted on a clock edge produces a single-cycle `sel_valid` pulse. The pulse appears NMOD+1 edges later, and the new selects appear in the same cycle.
- R9: `up_sel` and `low_sel` change only in the cycle in which `sel_valid` is 1.
- R10: A strobe that arrives while modules are still being ranked is ignored and produces no result. A strobe that arrives on the publishing edge is accepted and starts a new assignment. The result being published on that edge is unaffected.
- R11: Inputs are sampled only on the edge that accepts the strobe. Changing them afterwards has no effect on that result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_change | input | 1 | Strobe: the modulator's command levels changed |
| interval_code | input | 3 | Sixth-of-cycle code 0..5 (6, 7 aliased) |
| sw_count | input | 6*CW | Per-switch module counts, six fields |
| i_upper | input | NMOD*DW | Signed upper inductor current per module, module 0 in the low bits |
| i_lower | input | NMOD*DW | Signed lower inductor current per module |
| v_phase | input | 3*DW | Signed phase voltages, A in the low bits, then B, then C |
| up_sel | output | 3*NMOD | One-hot upper phase select per module |
| low_sel | output | 3*NMOD | One-hot lower phase select per module |
| sel_valid | output | 1 | One-cycle pulse marking newly published selects |

## Verification
Publishing a finished assignment and accepting the next strobe can fall on the same clock edge. This edge is the one place where the capture registers are overwritten while the mapper still reads them. The bench provokes it by raising the strobe with fresh inputs exactly one cycle before the expected valid pulse. It then checks two things. First, the pulse in that cycle carries the earlier assignment. Second, a full NMOD+1 edges later, a second pulse carries the assignment for the new inputs. Earlier in the same sequence, a strobe is also raised in the middle of ranking. It is judged ignored when the first result still matches its own inputs and no extra pulse follows the second one.

// File: rtl/iba_pkg.sv
`timescale 1ns/1ps
package iba_pkg;

  typedef enum logic [1:0] {ST_IDLE, ST_RANK, ST_PUBLISH} seq_state_t;

  localparam logic [1:0] PH_A = 2'd0;
  localparam logic [1:0] PH_B = 2'd1;
  localparam logic [1:0] PH_C = 2'd2;

  // Even codes share the upper switch of the peak phase across all modules.
  function automatic logic upper_is_common(input logic [2:0] code);
    return ~code[0];
  endfunction

  // Phase at its extreme for each sixth; codes 6 and 7 alias 0 and 3.
  function automatic logic [1:0] peak_phase(input logic [2:0] code);
    case (code)
      3'd2, 3'd5: return PH_B;
      3'd1, 3'd4: return PH_C;
      default:    return PH_A;
    endcase
  endfunction

  function automatic logic [2:0] phase_onehot(input logic [1:0] ph);
    case (ph)
      PH_B:    return 3'b010;
      PH_C:    return 3'b100;
      default: return 3'b001;
    endcase
  endfunction

  // Slot of the ordered phase list that a module of the given rank fills.
  function automatic logic [1:0] pick_slot(input int rank, input int c0, input int c1);
    if (rank < c0)      return 2'd0;
    if (rank < c0 + c1) return 2'd1;
    return 2'd2;
  endfunction

endpackage

// File: rtl/iba_rank_unit.sv
`timescale 1ns/1ps
module iba_rank_unit #(
  parameter int NMOD = 3,
  parameter int DW   = 16,
  parameter int IW   = 2,
  parameter int RW   = 2
) (
  input  logic [NMOD*DW-1:0] cur_flat,
  input  logic [IW-1:0]      sel_idx,
  output logic [RW-1:0]      rank
);

  logic signed [DW-1:0] own_cur;
  logic [NMOD-1:0]      beats;

  assign own_cur = $signed(cur_flat[sel_idx*DW +: DW]);

  genvar j;
  generate
    for (j = 0; j < NMOD; j++) begin : g_cmp
      logic signed [DW-1:0] other_cur;
      assign other_cur = $signed(cur_flat[j*DW +: DW]);
      assign beats[j] = (other_cur < own_cur) ||
                        ((other_cur == own_cur) && (IW'(j) < sel_idx));
    end
  endgenerate

  always_comb begin
    rank = '0;
    for (int k = 0; k < NMOD; k++) rank = rank + RW'(beats[k]);
  end

endmodule

// File: rtl/iba_phase_order.sv
`timescale 1ns/1ps
module iba_phase_order #(
  parameter int DW = 16
) (
  input  logic [3*DW-1:0] v_flat,
  input  logic            descending,
  output logic [5:0]      ord
);

  logic signed [DW-1:0] va, vb, vc;
  logic ab, ac, bc;
  logic [1:0] pos_a, pos_b, pos_c;

  assign va = $signed(v_flat[0*DW +: DW]);
  assign vb = $signed(v_flat[1*DW +: DW]);
  assign vc = $signed(v_flat[2*DW +: DW]);

  // "x before y" for x of lower letter: ties keep letter order.
  assign ab = descending ? (va >= vb) : (va <= vb);
  assign ac = descending ? (va >= vc) : (va <= vc);
  assign bc = descending ? (vb >= vc) : (vb <= vc);

  assign pos_a = {1'b0, ~ab} + {1'b0, ~ac};
  assign pos_b = {1'b0,  ab} + {1'b0, ~bc};
  assign pos_c = {1'b0,  ac} + {1'b0,  bc};

  always_comb begin
    ord = '0;
    ord[pos_a*2 +: 2] = 2'd0;
    ord[pos_b*2 +: 2] = 2'd1;
    ord[pos_c*2 +: 2] = 2'd2;
  end

endmodule

// File: rtl/iba_switch_map.sv
`timescale 1ns/1ps
module iba_switch_map import iba_pkg::*; #(
  parameter int NMOD = 3,
  parameter int RW   = 2,
  parameter int CW   = 2
) (
  input  logic [NMOD*RW-1:0] rank_flat,
  input  logic [5:0]         ord,
  input  logic [CW-1:0]      c0,
  input  logic [CW-1:0]      c1,
  input  logic               upper_common,
  input  logic [1:0]         peak,
  output logic [3*NMOD-1:0]  up_sel,
  output logic [3*NMOD-1:0]  low_sel
);

  logic [2:0] common_oh;
  assign common_oh = phase_onehot(peak);

  genvar k;
  generate
    for (k = 0; k < NMOD; k++) begin : g_mod
      logic [1:0] slot;
      logic [1:0] ph;
      logic [2:0] dist_oh;
      always_comb begin
        slot    = pick_slot(int'(rank_flat[k*RW +: RW]), int'(c0), int'(c1));
        ph      = ord[slot*2 +: 2];
        dist_oh = phase_onehot(ph);
      end
      assign up_sel[3*k +: 3]  = upper_common ? common_oh : dist_oh;
      assign low_sel[3*k +: 3] = upper_common ? dist_oh   : common_oh;
    end
  endgenerate

endmodule

// File: rtl/ind_balance_assigner.sv
`timescale 1ns/1ps
module ind_balance_assigner import iba_pkg::*; #(
  parameter int NMOD = 3,
  parameter int DW   = 16,
  parameter int CW   = $clog2(NMOD + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pwm_change,
  input  logic [2:0]           interval_code,
  input  logic [6*CW-1:0]      sw_count,
  input  logic [NMOD*DW-1:0]   i_upper,
  input  logic [NMOD*DW-1:0]   i_lower,
  input  logic [3*DW-1:0]      v_phase,
  output logic [3*NMOD-1:0]    up_sel,
  output logic [3*NMOD-1:0]    low_sel,
  output logic                 sel_valid
);

  localparam int RW = $clog2(NMOD + 1);
  localparam int IW = (NMOD > 1) ? $clog2(NMOD) : 1;
  localparam logic [IW-1:0] LAST_IDX = IW'(NMOD - 1);

  seq_state_t          state_q;
  logic [IW-1:0]       idx_q;
  logic [NMOD*DW-1:0]  cur_q;
  logic [5:0]          ord_q;
  logic [CW-1:0]       c0_q, c1_q;
  logic                ucom_q;
  logic [1:0]          peak_q;
  logic [RW-1:0]       rank_q [NMOD];
  logic [NMOD*RW-1:0]  rank_flat;

  // Named events for the checker.
  logic accept_ev, rank_step_ev, publish_ev;
  assign rank_step_ev = (state_q == ST_RANK);
  assign publish_ev   = (state_q == ST_PUBLISH);
  assign accept_ev    = pwm_change && !rank_step_ev;

  // Live decode used at capture.
  logic        ucom_w;
  logic [1:0]  peak_w;
  logic [5:0]  ord_w;
  logic [CW-1:0] dcnt [3];
  logic [CW-1:0] c0_w, c1_w;

  assign ucom_w = upper_is_common(interval_code);
  assign peak_w = peak_phase(interval_code);

  iba_phase_order #(.DW(DW)) u_order (
    .v_flat     (v_phase),
    .descending (ucom_w),
    .ord        (ord_w)
  );

  always_comb begin
    for (int p = 0; p < 3; p++)
      dcnt[p] = sw_count[(2*p + (ucom_w ? 1 : 0))*CW +: CW];
  end
  assign c0_w = dcnt[ord_w[1:0]];
  assign c1_w = dcnt[ord_w[3:2]];

  // One module ranked per cycle.
  logic [RW-1:0] rank_w;
  iba_rank_unit #(.NMOD(NMOD), .DW(DW), .IW(IW), .RW(RW)) u_rank (
    .cur_flat (cur_q),
    .sel_idx  (idx_q),
    .rank     (rank_w)
  );

  always_comb begin
    for (int k = 0; k < NMOD; k++) rank_flat[k*RW +: RW] = rank_q[k];
  end

  logic [3*NMOD-1:0] map_up, map_low;
  iba_switch_map #(.NMOD(NMOD), .RW(RW), .CW(CW)) u_map (
    .rank_flat    (rank_flat),
    .ord          (ord_q),
    .c0           (c0_q),
    .c1           (c1_q),
    .upper_common (ucom_q),
    .peak         (peak_q),
    .up_sel       (map_up),
    .low_sel      (map_low)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      idx_q     <= '0;
      cur_q     <= '0;
      ord_q     <= 6'b10_01_00;
      c0_q      <= '0;
      c1_q      <= '0;
      ucom_q    <= 1'b1;
      peak_q    <= PH_A;
      up_sel    <= {NMOD{3'b001}};
      low_sel   <= {NMOD{3'b001}};
      sel_valid <= 1'b0;
      for (int k = 0; k < NMOD; k++) rank_q[k] <= '0;
    end else begin
      sel_valid <= publish_ev;
      if (publish_ev) begin
        up_sel  <= map_up;
        low_sel <= map_low;
      end
      if (rank_step_ev) begin
        rank_q[idx_q] <= rank_w;
        if (idx_q == LAST_IDX) begin
          idx_q   <= '0;
          state_q <= ST_PUBLISH;
        end else begin
          idx_q <= idx_q + 1'b1;
        end
      end else if (accept_ev) begin
        cur_q   <= ucom_w ? i_lower : i_upper;
        ord_q   <= ord_w;
        c0_q    <= c0_w;
        c1_q    <= c1_w;
        ucom_q  <= ucom_w;
        peak_q  <= peak_w;
        idx_q   <= '0;
        state_q <= ST_RANK;
      end else if (publish_ev) begin
        state_q <= ST_IDLE;
      end
    end
  end

endmodule

// File: rtl/iba_checker.sv
`timescale 1ns/1ps
module iba_checker import iba_pkg::*; #(
  parameter int NMOD = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        interval_code,
  input logic [3*NMOD-1:0] up_sel,
  input logic [3*NMOD-1:0] low_sel,
  input logic              sel_valid,
  input logic              accept_ev,
  input logic              publish_ev
);

  int unsigned age_q;
  logic [2:0]  code_q, pub_code_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age_q      <= 0;
      code_q     <= '0;
      pub_code_q <= '0;
    end else begin
      if (accept_ev) begin
        age_q  <= 1;
        code_q <= interval_code;
      end else if (age_q != 0 && age_q < NMOD + 2) begin
        age_q <= age_q + 1;
      end
      if (publish_ev) pub_code_q <= code_q;
    end
  end

  genvar k;
  generate
    for (k = 0; k < NMOD; k++) begin : g_chk
      AST_UP_ONE_HOT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(up_sel[3*k +: 3]) == 1); // R1
      AST_LOW_ONE_HOT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(low_sel[3*k +: 3]) == 1); // R1
      AST_COMMON_SIDE: assert property (@(posedge clk) disable iff (!rst_n)
        sel_valid |-> (upper_is_common(pub_code_q)
          ? (up_sel[3*k +: 3]  == phase_onehot(peak_phase(pub_code_q)))
          : (low_sel[3*k +: 3] == phase_onehot(peak_phase(pub_code_q))))); // R2
    end
  endgenerate

  AST_PUBLISH_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    publish_ev |-> (age_q == NMOD + 1)); // R8
  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid |=> !sel_valid); // R8
  AST_HOLD_SELECTS: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_valid |-> ($stable(up_sel) && $stable(low_sel))); // R9
  AST_NO_ACCEPT_WHILE_RANKING: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q != 0 && age_q <= NMOD) |-> !accept_ev); // R10

endmodule

bind ind_balance_assigner iba_checker #(.NMOD(NMOD)) u_iba_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .interval_code (interval_code),
  .up_sel        (up_sel),
  .low_sel       (low_sel),
  .sel_valid     (sel_valid),
  .accept_ev     (accept_ev),
  .publish_ev    (publish_ev)
);

// File: tb/tb_ind_balance_assigner.sv
`timescale 1ns/1ps
module tb_ind_balance_assigner;

  localparam int M  = 3;
  localparam int DW = 16;
  localparam int CW = $clog2(M + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwm_change = 1'b0;
  logic [2:0]      interval_code;
  logic [6*CW-1:0] sw_count;
  logic [M*DW-1:0] i_upper, i_lower;
  logic [3*DW-1:0] v_phase;
  logic [3*M-1:0]  up_sel, low_sel;
  logic            sel_valid;

  int tb_code;
  int tb_cnt [6];
  logic signed [DW-1:0] tb_iu [M];
  logic signed [DW-1:0] tb_il [M];
  logic signed [DW-1:0] tb_v  [3];

  int exp_up [M];
  int exp_lo [M];
  int exp_nu [3];
  int exp_nl [3];
  bit exp_cnt_ok;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  always_comb begin
    interval_code = 3'(tb_code);
    for (int n = 0; n < 6; n++) sw_count[n*CW +: CW] = CW'(tb_cnt[n]);
    for (int m = 0; m < M; m++) begin
      i_upper[m*DW +: DW] = tb_iu[m];
      i_lower[m*DW +: DW] = tb_il[m];
    end
    for (int p = 0; p < 3; p++) v_phase[p*DW +: DW] = tb_v[p];
  end

  ind_balance_assigner #(.NMOD(M), .DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .pwm_change(pwm_change),
    .interval_code(interval_code), .sw_count(sw_count),
    .i_upper(i_upper), .i_lower(i_lower), .v_phase(v_phase),
    .up_sel(up_sel), .low_sel(low_sel), .sel_valid(sel_valid)
  );

  task automatic check(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  function automatic int ph_of(input logic [2:0] oh);
    if (oh == 3'b001) return 0;
    if (oh == 3'b010) return 1;
    if (oh == 3'b100) return 2;
    return 9;
  endfunction

  // Reference model written from the requirements (R2..R7).
  task automatic compute_expected();
    int ord_m [M];
    int ord_p [3];
    int cur [M];
    int dc [3];
    int pk, tmp, sum;
    bit odd;
    odd = (tb_code == 0 || tb_code == 2 || tb_code == 4 || tb_code == 6);
    pk  = (tb_code == 2 || tb_code == 5) ? 1 :
          (tb_code == 1 || tb_code == 4) ? 2 : 0;
    for (int i = 0; i < M; i++) begin
      cur[i]   = odd ? int'(tb_il[i]) : int'(tb_iu[i]);
      ord_m[i] = i;
    end
    for (int i = 1; i < M; i++)
      for (int j = i; j > 0; j--)
        if (cur[ord_m[j]] < cur[ord_m[j-1]]) begin
          tmp = ord_m[j]; ord_m[j] = ord_m[j-1]; ord_m[j-1] = tmp;
        end
    for (int p = 0; p < 3; p++) ord_p[p] = p;
    for (int i = 1; i < 3; i++)
      for (int j = i; j > 0; j--)
        if (odd ? (tb_v[ord_p[j]] > tb_v[ord_p[j-1]])
                : (tb_v[ord_p[j]] < tb_v[ord_p[j-1]])) begin
          tmp = ord_p[j]; ord_p[j] = ord_p[j-1]; ord_p[j-1] = tmp;
        end
    sum = 0;
    for (int p = 0; p < 3; p++) begin
      dc[p] = odd ? tb_cnt[2*p+1] : tb_cnt[2*p];
      sum += dc[p];
    end
    for (int r = 0; r < M; r++) begin
      int ph;
      if (r < dc[ord_p[0]]) ph = ord_p[0];
      else if (r < dc[ord_p[0]] + dc[ord_p[1]]) ph = ord_p[1];
      else ph = ord_p[2];
      if (odd) begin exp_up[ord_m[r]] = pk; exp_lo[ord_m[r]] = ph; end
      else     begin exp_lo[ord_m[r]] = pk; exp_up[ord_m[r]] = ph; end
    end
    for (int p = 0; p < 3; p++) begin
      exp_nu[p] = odd ? ((p == pk) ? M : 0) : dc[p];
      exp_nl[p] = odd ? dc[p] : ((p == pk) ? M : 0);
    end
    exp_cnt_ok = (sum == M);
  endtask

  task automatic check_selects(input string req);
    logic [3*M-1:0] eu, el;
    logic [11:0] act_n, exp_n;
    for (int m = 0; m < M; m++) begin
      eu[3*m +: 3] = 3'b001 << exp_up[m];
      el[3*m +: 3] = 3'b001 << exp_lo[m];
    end
    check(up_sel == eu && low_sel == el, req,
          {up_sel, low_sel}, {eu, el});
    if (exp_cnt_ok) begin
      int nu [3];
      int nl [3];
      for (int p = 0; p < 3; p++) begin nu[p] = 0; nl[p] = 0; end
      for (int m = 0; m < M; m++) begin
        if (ph_of(up_sel[3*m +: 3]) < 3)  nu[ph_of(up_sel[3*m +: 3])]++;
        if (ph_of(low_sel[3*m +: 3]) < 3) nl[ph_of(low_sel[3*m +: 3])]++;
      end
      for (int p = 0; p < 3; p++) begin
        act_n[4*p +: 2] = 2'(nu[p]); act_n[4*p+2 +: 2] = 2'(nl[p]);
        exp_n[4*p +: 2] = 2'(exp_nu[p]); exp_n[4*p+2 +: 2] = 2'(exp_nl[p]);
      end
      check(act_n == exp_n, "R3 per-switch module counts", act_n, exp_n);
    end
  endtask

  task automatic scramble();
    tb_code = $urandom_range(0, 7);
    for (int n = 0; n < 6; n++) tb_cnt[n] = $urandom_range(0, M);
    for (int m = 0; m < M; m++) begin
      tb_iu[m] = DW'($urandom);
      tb_il[m] = DW'($urandom);
    end
    for (int p = 0; p < 3; p++) tb_v[p] = DW'($urandom);
  endtask

  task automatic randomize_case(input int code);
    bit odd;
    bit tiny;
    tb_code = code;
    odd = (code % 2 == 0);
    tiny = ($urandom_range(0, 3) == 0);
    for (int n = 0; n < 6; n++) tb_cnt[n] = 0;
    for (int m = 0; m < M; m++) begin
      int p;
      p = $urandom_range(0, 2);
      if (odd) tb_cnt[2*p+1]++; else tb_cnt[2*p]++;
    end
    for (int m = 0; m < M; m++) begin
      tb_iu[m] = tiny ? DW'($urandom_range(0, 2)) : DW'($urandom);
      tb_il[m] = tiny ? DW'($urandom_range(0, 2)) : DW'($urandom);
    end
    for (int p = 0; p < 3; p++)
      tb_v[p] = tiny ? DW'($urandom_range(0, 1)) : DW'($urandom);
  endtask

  task automatic run_case(input string req);
    logic [3*M-1:0] pu, pl;
    @(negedge clk);
    compute_expected();
    pu = up_sel; pl = low_sel;
    pwm_change = 1'b1;
    @(posedge clk);
    @(negedge clk);
    pwm_change = 1'b0;
    scramble();  // R11: late changes must not matter
    repeat (M) @(posedge clk);
    @(negedge clk);
    check(sel_valid == 1'b0 && up_sel == pu && low_sel == pl,
          "R9 selects held before publish", {sel_valid, up_sel, low_sel}, {1'b0, pu, pl});
    @(posedge clk);
    @(negedge clk);
    check(sel_valid == 1'b1, "R8 valid NMOD+1 edges after strobe", sel_valid, 1);
    check_selects(req);
    @(posedge clk);
    @(negedge clk);
    check(sel_valid == 1'b0, "R8 valid lasts one cycle", sel_valid, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R8 watchdog expired: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int svA_up [M];
    int svA_lo [M];
    int svA_nu [3];
    int svA_nl [3];
    bit svA_ok;
    int svB_up [M];
    int svB_lo [M];
    int svB_nu [3];
    int svB_nl [3];
    bit svB_ok;
    void'($urandom(32'd2024));
    scramble();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(sel_valid == 1'b0 && up_sel == {M{3'b001}} && low_sel == {M{3'b001}},
          "R1 reset state", {sel_valid, up_sel, low_sel}, {1'b0, {M{3'b001}}, {M{3'b001}}});

    // R4: upper common, lower shared by descending voltage
    tb_code = 0;
    tb_cnt = '{M, 0, 0, 1, 0, 2};
    tb_il = '{16'sd300, -16'sd200, 16'sd50};
    tb_iu = '{16'sd0, 16'sd0, 16'sd0};
    tb_v  = '{16'sd9000, -16'sd500, -16'sd8000};
    run_case("R4 lowest lower current to highest-voltage phase");

    // R5: lower common (code 3 -> A), uppers by ascending voltage
    tb_code = 3;
    tb_cnt = '{1, M, 1, 0, 1, 0};
    tb_iu = '{-16'sd5, 16'sd700, -16'sd900};
    tb_v  = '{16'sd100, -16'sd3000, 16'sd2500};
    run_case("R5 lowest upper current to lowest-voltage phase");

    // R6: all ties
    tb_code = 0;
    tb_cnt = '{M, 1, 0, 1, 0, 1};
    tb_il = '{16'sd7, 16'sd7, 16'sd7};
    tb_v  = '{16'sd4, 16'sd4, 16'sd4};
    run_case("R6 ties resolved by module index and phase letter");

    // R7: quotas short of NMOD
    tb_code = 2;
    tb_cnt = '{0, 1, M, 0, 0, 0};
    tb_il = '{16'sd10, 16'sd20, -16'sd30};
    tb_v  = '{-16'sd1, 16'sd2, 16'sd3};
    run_case("R7 remaining modules fall to third phase");

    // R2: aliased codes 6 and 7
    randomize_case(6);
    run_case("R2 code 6 behaves as code 0");
    randomize_case(7);
    run_case("R2 code 7 behaves as code 3");

    // R10: strobe during ranking ignored, strobe on publish edge accepted
    randomize_case(4);
    @(negedge clk);
    compute_expected();
    svA_up = exp_up; svA_lo = exp_lo; svA_nu = exp_nu; svA_nl = exp_nl; svA_ok = exp_cnt_ok;
    pwm_change = 1'b1;
    @(posedge clk);
    @(negedge clk);
    pwm_change = 1'b0;
    scramble();
    @(posedge clk);
    @(negedge clk);
    pwm_change = 1'b1;  // lands on a ranking edge
    @(posedge clk);
    @(negedge clk);
    pwm_change = 1'b0;
    repeat (M - 2) @(posedge clk);
    @(negedge clk);
    randomize_case(1);
    compute_expected();
    svB_up = exp_up; svB_lo = exp_lo; svB_nu = exp_nu; svB_nl = exp_nl; svB_ok = exp_cnt_ok;
    pwm_change = 1'b1;  // lands on the publishing edge
    @(posedge clk);
    @(negedge clk);
    pwm_change = 1'b0;
    exp_up = svA_up; exp_lo = svA_lo; exp_nu = svA_nu; exp_nl = svA_nl; exp_cnt_ok = svA_ok;
    check(sel_valid == 1'b1, "R10 first result published on restart edge", sel_valid, 1);
    check_selects("R10 first result unaffected by restart");
    scramble();
    exp_up = svB_up; exp_lo = svB_lo; exp_nu = svB_nu; exp_nl = svB_nl; exp_cnt_ok = svB_ok;
    repeat (M) @(posedge clk);
    @(negedge clk);
    check(sel_valid == 1'b0, "R10 no pulse before restarted result", sel_valid, 0);
    @(posedge clk);
    @(negedge clk);
    check(sel_valid == 1'b1, "R10 restarted result valid", sel_valid, 1);
    check_selects("R10 restarted result and R11 capture");
    for (int c = 0; c < M + 2; c++) begin
      @(negedge clk);
      check(sel_valid == 1'b0, "R10 ignored strobe adds no pulse", sel_valid, 0);
    end

    // Random mix: R4 R5 R3 R11
    for (int t = 0; t < 40; t++) begin
      randomize_case($urandom_range(0, 7));
      run_case("R4 R5 random assignment with R11 late input change");
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule